// File: doc/BRIEF.md
# Request-Triggered Single-Channel Byte Mover

This block is one channel of a direct memory access engine. It copies single bytes from a source region of a shared bus to a destination address. Each byte move waits for a pulse on a selected peripheral request line, such as a transmit-buffer-empty strobe. A move always takes two bus cycles: first a read at the source pointer, then a write of that byte at the destination pointer.

The source side and the destination side each have a start address, a byte count and a pointer mode (step up or stay fixed). Each side wraps back to its own start when its own count is reached. A source count of ten with a destination count of one therefore feeds ten bytes into one fixed register. When the source count completes, the channel disarms its trigger and pulses `done`.

Bus access follows a priority bit. In high mode the channel stalls the CPU while it owns the bus. In low mode it uses only cycles the CPU leaves idle. After a two-byte key, the priority bit can be frozen by a lock.

Channel states:
- `CH_IDLE`: waiting.
- `CH_READ`: the source read.
- `CH_WRITE`: the destination write.

Channel transitions:
- IDLE→READ when the channel is armed and a request or a latched request is present.
- READ→WRITE once the bus is usable.
- READ→IDLE when the channel is disabled.
- WRITE→IDLE once the write is issued.

Key detector states:
- `LK_WAIT`: no key byte seen.
- `LK_HAVE55`: the first key byte has been seen.
- `LK_ARMED`: both key bytes have been seen.

Key detector transitions:
- WAIT→HAVE55 on 0x55.
- HAVE55→ARMED on 0xAA.
- HAVE55→HAVE55 on another 0x55.
- Any other byte returns to WAIT.
- ARMED→WAIT on any write; the write sets the lock if its bit 0 is 1.

Top module: `dma_chan`

## Requirements
- R1: After reset, `bus_rd`, `bus_wr`, `cpu_stall`, `done`, `overrun`, `trig_armed` and `prio_locked` are all 0.
- R2: A byte move starts only on the request line chosen by register 10. It also needs control register 0 to have bit 0 (channel enable) and bit 1 (trigger enable) both set. Requests on other lines, or with either bit clear, cause no bus cycle.
- R3: The source start address is 24 bits, held in registers 1 (low), 2 and 3 (high). With control bit 2 set the source pointer steps by one after each move; with it clear the pointer stays fixed.
- R4: The destination start address is 16 bits, held in registers 4 (low) and 5 (high). Control bit 3 selects stepping or fixed for it, independently of the source.
- R5: The source count is in registers 6/7 and the destination count in registers 8/9 (low byte first); each count is at least 1. Each side reloads its own start address after its own count of moves.
- R6: Register 11 bit 0 selects the priority. When it is 1, `cpu_stall` is 1 while a move is in progress and the move proceeds even while `cpu_busy` is 1. When it is 0, `cpu_stall` stays 0 and bus cycles happen only while `cpu_busy` is 0.
- R7: Every move is a `bus_rd` at the source pointer, later followed by a `bus_wr` at the destination pointer carrying the byte read.
- R8: The write that completes the source count pulses `done` for one cycle and clears trigger enable; later requests cause no move.
- R9: A request that arrives while a move is in progress is latched once and performed afterwards. A second such request, while one is already latched, sets `overrun`. Any write to register 0 clears `overrun`.
- R10: Register 12 is the lock port. Writing 0x01 sets `prio_locked` only if the two writes to it just before were 0x55 and then 0xAA. A wrong byte restarts the detection.
- R11: While `prio_locked` is 1, writes to register 11 are ignored.
- R12: Clearing channel enable aborts at the next byte boundary and returns both counters and pointers to their start values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| req_in | input | NREQ | Peripheral request lines |
| cpu_busy | input | 1 | CPU uses the bus this cycle |
| bus_rdata | input | 8 | Read data for the current bus address |
| cpu_stall | output | 1 | Holds the CPU off the bus |
| bus_rd | output | 1 | Source read cycle |
| bus_wr | output | 1 | Destination write cycle |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 8 | Write data |
| done | output | 1 | Source count completed (pulse) |
| overrun | output | 1 | Request lost flag |
| trig_armed | output | 1 | Trigger enable state |
| prio_locked | output | 1 | Priority lock state |

## Verification
A wrong pointer or counter shows up as a wrong write address on the next move. A wrong wrap shows up within one count period, as a repeated or skipped destination address, or as a `done` pulse on the wrong write. A lost or doubled latched request shows as a missing or extra write about three cycles after the request burst. A wrong key-detector state shows as `prio_locked` set too early or not at all. After locking, the frozen priority is observed through `cpu_stall`, and through whether a move proceeds while `cpu_busy` is held.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [1:0] {CH_IDLE, CH_READ, CH_WRITE} ch_state_t;
    typedef enum logic [1:0] {LK_WAIT, LK_HAVE55, LK_ARMED} lk_state_t;

    localparam logic [3:0] RA_CTRL = 4'd0;
    localparam logic [3:0] RA_SRC0 = 4'd1;
    localparam logic [3:0] RA_SRC1 = 4'd2;
    localparam logic [3:0] RA_SRC2 = 4'd3;
    localparam logic [3:0] RA_DST0 = 4'd4;
    localparam logic [3:0] RA_DST1 = 4'd5;
    localparam logic [3:0] RA_SSZ0 = 4'd6;
    localparam logic [3:0] RA_SSZ1 = 4'd7;
    localparam logic [3:0] RA_DSZ0 = 4'd8;
    localparam logic [3:0] RA_DSZ1 = 4'd9;
    localparam logic [3:0] RA_RSEL = 4'd10;
    localparam logic [3:0] RA_PRIO = 4'd11;
    localparam logic [3:0] RA_LOCK = 4'd12;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/dma_ptr.sv
module dma_ptr #(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic          step,
    input  logic          inc,
    input  logic [AW-1:0] start,
    input  logic [CW-1:0] size,
    output logic [AW-1:0] ptr,
    output logic          wrap
);
    logic [CW-1:0] cnt;

    assign wrap = step && ((cnt + 1'b1) == size);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ptr <= '0;
        end else if (reload || wrap) begin
            cnt <= '0;
            ptr <= start;
        end else if (step) begin
            cnt <= cnt + 1'b1;
            if (inc) ptr <= ptr + 1'b1;
        end
    end

    // R3 / R4: a fixed pointer only ever holds or reloads
    a_r3_fixed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !inc && !reload) |=> (ptr == $past(ptr) || ptr == $past(start)));
endmodule

// File: rtl/dma_lock.sv
module dma_lock
    import dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_lock,
    input  logic       we_prio,
    input  logic [7:0] wdata,
    output logic       prio_hi,
    output logic       locked
);
    lk_state_t lk, lk_nxt;
    logic      set_lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk <= LK_WAIT;
        else        lk <= lk_nxt;
    end

    always_comb begin
        lk_nxt   = lk;
        set_lock = 1'b0;
        if (we_lock) begin
            unique case (lk)
                LK_WAIT:   lk_nxt = (wdata == KEY_FIRST) ? LK_HAVE55 : LK_WAIT;
                LK_HAVE55: lk_nxt = (wdata == KEY_SECOND) ? LK_ARMED :
                                    (wdata == KEY_FIRST)  ? LK_HAVE55 : LK_WAIT;
                LK_ARMED: begin
                    lk_nxt   = LK_WAIT;
                    set_lock = wdata[0];
                end
                default:   lk_nxt = LK_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked  <= 1'b0;
            prio_hi <= 1'b0;
        end else begin
            if (set_lock) locked <= 1'b1;
            if (we_prio && !locked) prio_hi <= wdata[0];
        end
    end

    // R10: the lock rises only from the armed state
    a_r10_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(lk) == LK_ARMED);
    // R10: the lock is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
    // R11: priority frozen while locked
    a_r11_prio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(prio_hi));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [3:0]      reg_addr,
    input  logic [7:0]      reg_wdata,
    input  logic [NREQ-1:0] req_in,
    input  logic            cpu_busy,
    input  logic [7:0]      bus_rdata,
    output logic            cpu_stall,
    output logic            bus_rd,
    output logic            bus_wr,
    output logic [23:0]     bus_addr,
    output logic [7:0]      bus_wdata,
    output logic            done,
    output logic            overrun,
    output logic            trig_armed,
    output logic            prio_locked
);
    localparam int SAW   = 24;
    localparam int DAW   = 16;
    localparam int CW    = 16;
    localparam int SEL_W = (NREQ > 1) ? $clog2(NREQ) : 1;

    ch_state_t        st, st_nxt;
    logic             chan_en, trig_en, src_inc, dst_inc;
    logic [SAW-1:0]   src_start, src_ptr;
    logic [DAW-1:0]   dst_start, dst_ptr;
    logic [CW-1:0]    src_size, dst_size;
    logic [SEL_W-1:0] rsel;
    logic [7:0]       data_q;
    logic             pend, prio_hi;
    logic             req_hit, active, bus_go, step, reload, src_wrap, dst_wrap;

    assign req_hit    = req_in[rsel];
    assign active     = chan_en && trig_en;
    assign bus_go     = prio_hi || !cpu_busy;
    assign trig_armed = trig_en;

    // register port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {chan_en, trig_en, src_inc, dst_inc} <= '0;
            src_start <= '0;
            dst_start <= '0;
            src_size  <= CW'(1);
            dst_size  <= CW'(1);
            rsel      <= '0;
        end else begin
            if (reg_we) begin
                unique case (reg_addr)
                    RA_CTRL: {dst_inc, src_inc, trig_en, chan_en} <= reg_wdata[3:0];
                    RA_SRC0: src_start[7:0]   <= reg_wdata;
                    RA_SRC1: src_start[15:8]  <= reg_wdata;
                    RA_SRC2: src_start[23:16] <= reg_wdata;
                    RA_DST0: dst_start[7:0]   <= reg_wdata;
                    RA_DST1: dst_start[15:8]  <= reg_wdata;
                    RA_SSZ0: src_size[7:0]    <= reg_wdata;
                    RA_SSZ1: src_size[15:8]   <= reg_wdata;
                    RA_DSZ0: dst_size[7:0]    <= reg_wdata;
                    RA_DSZ1: dst_size[15:8]   <= reg_wdata;
                    RA_RSEL: rsel             <= reg_wdata[SEL_W-1:0];
                    default: ;
                endcase
            end
            if (done) trig_en <= 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CH_IDLE;
        else        st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            CH_IDLE:  if (active && (pend || req_hit)) st_nxt = CH_READ;
            CH_READ:  if (!chan_en) st_nxt = CH_IDLE;
                      else if (bus_go) st_nxt = CH_WRITE;
            CH_WRITE: if (bus_go) st_nxt = CH_IDLE;
            default:  st_nxt = CH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_rd    = (st == CH_READ) && chan_en && bus_go;
        bus_wr    = (st == CH_WRITE) && bus_go;
        bus_addr  = (st == CH_READ) ? src_ptr : {{(SAW-DAW){1'b0}}, dst_ptr};
        bus_wdata = data_q;
        cpu_stall = prio_hi && (st != CH_IDLE);
        step      = bus_wr;
        done      = bus_wr && src_wrap;
        reload    = (st == CH_IDLE) && !chan_en;
    end

    // read data, request latch, overrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            pend    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (bus_rd) data_q <= bus_rdata;
            if (reg_we && reg_addr == RA_CTRL) overrun <= 1'b0;
            if (!chan_en) begin
                pend <= 1'b0;
            end else if (st == CH_IDLE) begin
                if (st_nxt == CH_READ) pend <= pend && req_hit;
            end else if (req_hit && trig_en) begin
                if (pend) overrun <= 1'b1;
                else      pend    <= 1'b1;
            end
            if (done) pend <= 1'b0;
        end
    end

    dma_ptr #(.AW(SAW), .CW(CW)) u_src (
        .clk(clk), .rst_n(rst_n), .reload(reload), .step(step), .inc(src_inc),
        .start(src_start), .size(src_size), .ptr(src_ptr), .wrap(src_wrap));

    dma_ptr #(.AW(DAW), .CW(CW)) u_dst (
        .clk(clk), .rst_n(rst_n), .reload(reload), .step(step), .inc(dst_inc),
        .start(dst_start), .size(dst_size), .ptr(dst_ptr), .wrap(dst_wrap));

    dma_lock u_lock (
        .clk(clk), .rst_n(rst_n),
        .we_lock(reg_we && reg_addr == RA_LOCK),
        .we_prio(reg_we && reg_addr == RA_PRIO),
        .wdata(reg_wdata), .prio_hi(prio_hi), .locked(prio_locked));

    // R7: never a read and a write together
    a_r7_one_cycle_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd, bus_wr}));
    // R7: a read is followed by the write phase
    a_r7_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (st == CH_WRITE));
    // R6: low priority uses only idle CPU cycles
    a_r6_bubble_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && !prio_hi) |-> !cpu_busy);
    // R6: stall only in high priority
    a_r6_stall_hi: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> prio_hi);
    // R8: done disarms the trigger
    a_r8_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !trig_en);
    // R9: overrun rises only during a move
    a_r9_overrun_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(st) != CH_IDLE);
endmodule

// File: tb/test_dma_chan.sv
module test_dma_chan;
    localparam int CLK_PERIOD = 10;
    localparam int NREQ = 4;

    logic            clk = 0, rst_n = 0;
    logic            reg_we = 0;
    logic [3:0]      reg_addr = 0;
    logic [7:0]      reg_wdata = 0;
    logic [NREQ-1:0] req_in = 0;
    logic            cpu_busy = 0;
    logic [7:0]      bus_rdata;
    logic            cpu_stall, bus_rd, bus_wr, done, overrun, trig_armed, prio_locked;
    logic [23:0]     bus_addr;
    logic [7:0]      bus_wdata;

    int checks = 0, errors = 0, wr_count = 0, done_count = 0, cycles = 0;
    bit rd_seen = 0, finished = 0;
    logic [31:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction
    assign bus_rdata = mem_f(bus_addr);

    dma_chan #(.NREQ(NREQ)) i_dma_chan (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .req_in(req_in), .cpu_busy(cpu_busy),
        .bus_rdata(bus_rdata), .cpu_stall(cpu_stall), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .done(done), .overrun(overrun), .trig_armed(trig_armed),
        .prio_locked(prio_locked));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // monitor: pops expected writes
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_rd) rd_seen = 1;
            if (bus_wr) begin
                wr_count++;
                check("R7 read before write", {31'd0, rd_seen}, 32'd1);
                rd_seen = 0;
                if (exp_q.size() == 0) begin
                    check("R2 unexpected write", {bus_addr, bus_wdata}, 32'hFFFFFFFF);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check("R3 R4 R5 write addr/data", {bus_addr, bus_wdata}, e);
                end
            end
            if (done) done_count++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            summary();
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic cfg(input logic [23:0] s, input logic [15:0] ssz,
                       input logic [15:0] d, input logic [15:0] dsz,
                       input logic [7:0] sel);
        wr(0, 8'h00);
        wr(1, s[7:0]); wr(2, s[15:8]); wr(3, s[23:16]);
        wr(4, d[7:0]); wr(5, d[15:8]);
        wr(6, ssz[7:0]); wr(7, ssz[15:8]);
        wr(8, dsz[7:0]); wr(9, dsz[15:8]);
        wr(10, sel);
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        req_in[line] = 1;
        @(negedge clk);
        req_in = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_move(input logic [15:0] d, input logic [23:0] s, input int line);
        exp_q.push_back({8'h00, d, mem_f(s)});
        pulse(line);
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int w0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 bus_rd", {31'd0, bus_rd}, 0);
        check("R1 bus_wr", {31'd0, bus_wr}, 0);
        check("R1 cpu_stall", {31'd0, cpu_stall}, 0);
        check("R1 flags", {28'd0, done, overrun, trig_armed, prio_locked}, 0);
        rst_n = 1;
        idle_wait(2);

        // R2 gating
        cfg(24'h012340, 4, 16'h0800, 4, 8'd2);
        w0 = wr_count;
        pulse(2);
        check("R2 no move while disabled", wr_count, w0);
        wr(0, 8'h0D);
        pulse(2);
        check("R2 no move without trigger enable", wr_count, w0);
        wr(0, 8'h0F);
        pulse(1);
        check("R2 no move on unselected line", wr_count, w0);
        for (int i = 0; i < 4; i++) expect_move(16'h0800 + 16'(i), 24'h012340 + 24'(i), 2);
        check("R3 R4 all stepped writes seen", exp_q.size(), 0);
        check("R8 one done pulse", done_count, 1);
        check("R8 trigger disarmed", {31'd0, trig_armed}, 0);
        w0 = wr_count;
        pulse(2);
        check("R8 no move after done", wr_count, w0);

        // R5 ten bytes to one fixed register
        cfg(24'h020000, 10, 16'h00F0, 1, 8'd0);
        wr(0, 8'h07);
        for (int i = 0; i < 10; i++) expect_move(16'h00F0, 24'h020000 + 24'(i), 0);
        check("R5 ten writes to fixed destination", exp_q.size(), 0);
        check("R5 done after source count", done_count, 2);

        // R3 fixed source, R4 stepping destination, R5 destination wraps at 2
        cfg(24'h0300AA, 3, 16'h0900, 2, 8'd3);
        wr(0, 8'h0B);
        expect_move(16'h0900, 24'h0300AA, 3);
        expect_move(16'h0901, 24'h0300AA, 3);
        expect_move(16'h0900, 24'h0300AA, 3);
        check("R5 destination wrapped", exp_q.size(), 0);

        // R9 latched request and overrun
        cfg(24'h040000, 8, 16'h0A00, 8, 8'd1);
        wr(0, 8'h0F);
        exp_q.push_back({8'h00, 16'h0A00, mem_f(24'h040000)});
        exp_q.push_back({8'h00, 16'h0A01, mem_f(24'h040001)});
        @(negedge clk);
        req_in[1] = 1;
        repeat (3) @(negedge clk);
        req_in = '0;
        idle_wait(6);
        check("R9 latched request performed", exp_q.size(), 0);
        check("R9 overrun set", {31'd0, overrun}, 1);
        wr(0, 8'h0F);
        check("R9 overrun cleared", {31'd0, overrun}, 0);

        // R6 low priority waits for idle cycles
        cpu_busy = 1;
        w0 = wr_count;
        exp_q.push_back({8'h00, 16'h0A02, mem_f(24'h040002)});
        pulse(1);
        check("R6 low priority blocked by busy CPU", wr_count, w0);
        check("R6 no stall in low priority", {31'd0, cpu_stall}, 0);
        cpu_busy = 0;
        idle_wait(4);
        check("R6 move after CPU idle", wr_count, w0 + 1);

        // R6 high priority stalls the CPU
        wr(11, 8'h01);
        cpu_busy = 1;
        w0 = wr_count;
        exp_q.push_back({8'h00, 16'h0A03, mem_f(24'h040003)});
        @(negedge clk);
        req_in[1] = 1;
        @(negedge clk);
        req_in = '0;
        check("R6 stall during high priority move", {31'd0, cpu_stall}, 1);
        idle_wait(4);
        check("R6 high priority move done under busy", wr_count, w0 + 1);
        cpu_busy = 0;

        // R12 abort resets counters
        expect_move(16'h0A04, 24'h040004, 1);
        wr(0, 8'h00);
        wr(0, 8'h0F);
        expect_move(16'h0A00, 24'h040000, 1);
        check("R12 restart from start addresses", exp_q.size(), 0);

        // R10 unlock sequence
        wr(11, 8'h00);
        wr(12, 8'h01);
        check("R10 no lock without key", {31'd0, prio_locked}, 0);
        wr(12, 8'h55); wr(12, 8'h12); wr(12, 8'hAA); wr(12, 8'h01);
        check("R10 wrong byte resets key", {31'd0, prio_locked}, 0);
        wr(12, 8'h55); wr(12, 8'hAA); wr(12, 8'h01);
        check("R10 lock set after key", {31'd0, prio_locked}, 1);

        // R11 priority write ignored after lock
        wr(11, 8'h01);
        cpu_busy = 1;
        w0 = wr_count;
        exp_q.push_back({8'h00, 16'h0A01, mem_f(24'h040001)});
        pulse(1);
        check("R11 stall stays off", {31'd0, cpu_stall}, 0);
        check("R11 still low priority", wr_count, w0);
        cpu_busy = 0;
        idle_wait(4);
        check("R11 move after CPU idle", wr_count, w0 + 1);
        check("R1 queue drained", exp_q.size(), 0);
        summary();
    end
endmodule